// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block keeps track of instructions that were issued speculatively and may finish out of order, and it retires them strictly in program order. Each issued instruction takes the slot at the tail of a circular queue. The slot index goes back to the issue stage and serves as the instruction's tag. Execution units later broadcast their results on a single result bus under that tag. The buffer captures each result and holds it until the instruction reaches the head. While a result is held, the issue stage can read it through two lookup ports, so a value that has not yet retired can still be forwarded.

At the head, the instruction's kind decides what happens on retirement:
- An ordinary instruction writes its destination register.
- A store sends a write request to memory. Its data may be known at issue, or it may arrive later when the result bus carries the tag of the instruction that produces it.
- A branch that resolved as mispredicted empties the whole buffer in one cycle and outputs the corrected fetch address.

The register file, the memory system and the branch predictor sit outside the block.

Top module: `spec_rob`

## Requirements
- R1: Instructions retire in the order they were allocated, at most one per cycle. Every allocated instruction that completes without exception or redirect eventually produces exactly one commit action.
- R2: With DEPTH (8) instructions outstanding, `alloc_ok` is low. A request made while full allocates nothing and leaves `alloc_tag` unchanged.
- R3: `alloc_tag` shows the slot that the next allocation takes. Tags start at 0 after reset and count up by one per accepted allocation, wrapping from DEPTH-1 to 0.
- R4: A result-bus beat whose tag names a valid, not yet complete, non-store entry stores `bus_value` in that entry and marks it complete. The entry also records `bus_exc` and `bus_mispred`.
- R5: A store (kind 1) is complete once its data is known. The data comes from `alloc_src_val` when `alloc_src_rdy` is set. Otherwise it comes from the first result-bus beat carrying `alloc_src_tag`, and that beat may occur in the same cycle as the allocation.
- R6: A lookup port reports ready, with the entry's value, only when its tag names a valid and complete entry. Otherwise it reports not ready.
- R7: A complete entry at the head whose kind is neither 1 nor 2 and that has no exception raises `rf_we` for one cycle with its destination and value, and is then removed.
- R8: A complete store at the head with no exception raises `st_req` with its address and data, and raises no register write.
- R9: A complete branch (kind 2) at the head that is marked mispredicted raises `redirect_valid` with `redirect_pc` equal to its captured value. In the next cycle every entry is gone, tags restart at 0, and an allocation requested in the redirect cycle is dropped. A correctly predicted branch retires with no output.
- R10: A complete entry flagged with an exception retires without any register write, store or redirect.
- R11: While the head entry is not complete, nothing retires, even if younger entries are complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| alloc_req | input | 1 | Issue stage requests a slot |
| alloc_kind | input | 2 | 0 register op, 1 store, 2 branch |
| alloc_dest | input | RW (5) | Destination register |
| alloc_addr | input | XLEN (32) | Store address |
| alloc_src_rdy | input | 1 | Store data is known at issue |
| alloc_src_val | input | XLEN (32) | Store data when known |
| alloc_src_tag | input | IW (3) | Tag producing the store data otherwise |
| alloc_ok | output | 1 | A slot is free |
| alloc_tag | output | IW (3) | Tag given to the next allocation |
| rd0_tag | input | IW (3) | Lookup port 0 tag |
| rd0_ready | output | 1 | Lookup 0 value available |
| rd0_value | output | XLEN (32) | Lookup 0 value |
| rd1_tag | input | IW (3) | Lookup port 1 tag |
| rd1_ready | output | 1 | Lookup 1 value available |
| rd1_value | output | XLEN (32) | Lookup 1 value |
| bus_valid | input | 1 | Result bus beat |
| bus_tag | input | IW (3) | Tag of the result |
| bus_value | input | XLEN (32) | Result, or correct target for a branch |
| bus_exc | input | 1 | Result raised an exception |
| bus_mispred | input | 1 | Branch was mispredicted |
| rf_we | output | 1 | Register write strobe |
| rf_waddr | output | RW (5) | Register write address |
| rf_wdata | output | XLEN (32) | Register write data |
| st_req | output | 1 | Memory store request |
| st_addr | output | XLEN (32) | Store address |
| st_data | output | XLEN (32) | Store data |
| redirect_valid | output | 1 | Flush and restart fetch |
| redirect_pc | output | XLEN (32) | Restart address |

## Verification
The assertions check the following on every cycle:
- An allocation never lands on an occupied slot, and the allocated slot is valid afterwards.
- A matching bus beat completes its entry with the broadcast value.
- A retired register slot is freed.
- Nothing retires behind an incomplete head.
- A redirect leaves the buffer empty.

Some behaviours can only be shown by the bench's scenarios:
- The order and content of the commit stream under out-of-order completion.
- Late and same-cycle capture of store data.
- The silent retirement of excepting entries and correct branches.
- The refusal of an allocation while full, and the dropping of an allocation during a flush, both observed through the returned tags.

// File: rtl/srob_pkg.sv
package srob_pkg;

  typedef enum logic [1:0] {
    OP_REG    = 2'd0,
    OP_STORE  = 2'd1,
    OP_BRANCH = 2'd2
  } op_kind_e;

endpackage

// File: rtl/srob_ptrs.sv
// Head and tail pointers with a wrap bit; DEPTH must be a power of two.
module srob_ptrs #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_req,
  input  logic          flush,
  input  logic          pop,
  output logic          alloc_fire,
  output logic [IW-1:0] tail_idx,
  output logic [IW-1:0] head_idx,
  output logic          full,
  output logic          empty
);

  localparam int unsigned PW = IW + 1;

  logic [PW-1:0] head_q, head_d;
  logic [PW-1:0] tail_q, tail_d;
  logic          ptr_en;

  always_comb begin
    full       = (head_q[IW] != tail_q[IW]) && (head_q[IW-1:0] == tail_q[IW-1:0]);
    empty      = (head_q == tail_q);
    alloc_fire = alloc_req && !full && !flush;
    head_d     = head_q;
    tail_d     = tail_q;
    if (flush) begin
      head_d = '0;
      tail_d = '0;
    end else begin
      if (pop)        head_d = head_q + PW'(1);
      if (alloc_fire) tail_d = tail_q + PW'(1);
    end
    ptr_en = flush || pop || alloc_fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else if (ptr_en) begin
      head_q <= head_d;
      tail_q <= tail_d;
    end
  end

  assign tail_idx = tail_q[IW-1:0];
  assign head_idx = head_q[IW-1:0];

endmodule

// File: rtl/srob_entries.sv
// Entry storage: per-slot control, result capture and store-data snooping.
module srob_entries
  import srob_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned IW    = $clog2(DEPTH),
  parameter int unsigned XLEN  = 32,
  parameter int unsigned RW    = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            alloc_fire,
  input  logic [IW-1:0]   alloc_idx,
  input  logic [1:0]      alloc_kind,
  input  logic [RW-1:0]   alloc_dest,
  input  logic [XLEN-1:0] alloc_addr,
  input  logic            alloc_src_rdy,
  input  logic [XLEN-1:0] alloc_src_val,
  input  logic [IW-1:0]   alloc_src_tag,
  input  logic            bus_valid,
  input  logic [IW-1:0]   bus_tag,
  input  logic [XLEN-1:0] bus_value,
  input  logic            bus_exc,
  input  logic            bus_mispred,
  input  logic            pop,
  input  logic [IW-1:0]   pop_idx,
  output logic [DEPTH-1:0] valid_o,
  output logic [DEPTH-1:0] done_o,
  output logic [DEPTH-1:0] exc_o,
  output logic [DEPTH-1:0] misp_o,
  output logic [1:0]       kind_o  [DEPTH],
  output logic [RW-1:0]    dest_o  [DEPTH],
  output logic [XLEN-1:0]  addr_o  [DEPTH],
  output logic [XLEN-1:0]  value_o [DEPTH]
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic            v_q, v_d, dn_q, dn_d, ex_q, ex_d, mp_q, mp_d, wt_q, wt_d;
    logic [1:0]      k_q, k_d;
    logic [RW-1:0]   ds_q, ds_d;
    logic [XLEN-1:0] ad_q, ad_d, vl_q, vl_d;
    logic [IW-1:0]   wg_q, wg_d;
    logic            here_alloc, here_pop, own_hit, data_hit, slot_en;

    assign here_alloc = alloc_fire && (alloc_idx == IW'(i));
    assign here_pop   = pop && (pop_idx == IW'(i));
    assign own_hit    = bus_valid && (bus_tag == IW'(i)) && v_q && !dn_q && (k_q != OP_STORE);
    assign data_hit   = bus_valid && v_q && wt_q && (bus_tag == wg_q);

    always_comb begin
      v_d  = v_q;  dn_d = dn_q; ex_d = ex_q; mp_d = mp_q; wt_d = wt_q;
      k_d  = k_q;  ds_d = ds_q; ad_d = ad_q; vl_d = vl_q; wg_d = wg_q;
      if (flush) begin
        v_d  = 1'b0;
        dn_d = 1'b0;
        wt_d = 1'b0;
      end else if (here_alloc) begin
        v_d  = 1'b1;
        k_d  = alloc_kind;
        ds_d = alloc_dest;
        ad_d = alloc_addr;
        ex_d = 1'b0;
        mp_d = 1'b0;
        wg_d = alloc_src_tag;
        dn_d = 1'b0;
        wt_d = 1'b0;
        if (alloc_kind == OP_STORE) begin
          if (alloc_src_rdy) begin
            vl_d = alloc_src_val;
            dn_d = 1'b1;
          end else if (bus_valid && (bus_tag == alloc_src_tag)) begin
            vl_d = bus_value;
            dn_d = 1'b1;
          end else begin
            wt_d = 1'b1;
          end
        end
      end else if (here_pop) begin
        v_d  = 1'b0;
        dn_d = 1'b0;
        wt_d = 1'b0;
      end else begin
        if (own_hit) begin
          vl_d = bus_value;
          dn_d = 1'b1;
          ex_d = bus_exc;
          mp_d = bus_mispred;
        end
        if (data_hit) begin
          vl_d = bus_value;
          dn_d = 1'b1;
          wt_d = 1'b0;
        end
      end
      slot_en = flush || here_alloc || here_pop || own_hit || data_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0; dn_q <= 1'b0; ex_q <= 1'b0; mp_q <= 1'b0; wt_q <= 1'b0;
        k_q <= '0;   ds_q <= '0;   ad_q <= '0;   vl_q <= '0;   wg_q <= '0;
      end else if (slot_en) begin
        v_q <= v_d;  dn_q <= dn_d; ex_q <= ex_d; mp_q <= mp_d; wt_q <= wt_d;
        k_q <= k_d;  ds_q <= ds_d; ad_q <= ad_d; vl_q <= vl_d; wg_q <= wg_d;
      end
    end

    assign valid_o[i] = v_q;
    assign done_o[i]  = dn_q;
    assign exc_o[i]   = ex_q;
    assign misp_o[i]  = mp_q;
    assign kind_o[i]  = k_q;
    assign dest_o[i]  = ds_q;
    assign addr_o[i]  = ad_q;
    assign value_o[i] = vl_q;
  end

  // R2: the pointer logic only hands out a slot that is free
  a_r2_alloc_slot_free: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |-> !valid_o[alloc_idx]);

  // R3: an accepted allocation occupies its slot next cycle
  a_r3_alloc_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> valid_o[$past(alloc_idx)]);

  // R4: a matching bus beat completes the entry with the broadcast value
  a_r4_bus_marks_done: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !flush && valid_o[bus_tag] && !done_o[bus_tag] &&
     (kind_o[bus_tag] != OP_STORE) && !(pop && (pop_idx == bus_tag)))
    |=> (done_o[$past(bus_tag)] && (value_o[$past(bus_tag)] == $past(bus_value))));

endmodule

// File: rtl/srob_lookup.sv
// Operand lookup by tag for the issue stage.
module srob_lookup #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned IW    = $clog2(DEPTH),
  parameter int unsigned XLEN  = 32
) (
  input  logic [IW-1:0]    tag,
  input  logic [DEPTH-1:0] valid_i,
  input  logic [DEPTH-1:0] done_i,
  input  logic [XLEN-1:0]  value_i [DEPTH],
  output logic             ready,
  output logic [XLEN-1:0]  value
);

  always_comb begin
    ready = valid_i[tag] && done_i[tag];
    value = ready ? value_i[tag] : '0;
  end

endmodule

// File: rtl/srob_retire.sv
// Head decode: selects the commit action from the head entry's kind.
module srob_retire
  import srob_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned IW    = $clog2(DEPTH),
  parameter int unsigned XLEN  = 32,
  parameter int unsigned RW    = 5
) (
  input  logic [IW-1:0]    head_idx,
  input  logic [DEPTH-1:0] valid_i,
  input  logic [DEPTH-1:0] done_i,
  input  logic [DEPTH-1:0] exc_i,
  input  logic [DEPTH-1:0] misp_i,
  input  logic [1:0]       kind_i  [DEPTH],
  input  logic [RW-1:0]    dest_i  [DEPTH],
  input  logic [XLEN-1:0]  addr_i  [DEPTH],
  input  logic [XLEN-1:0]  value_i [DEPTH],
  output logic             pop,
  output logic             flush,
  output logic             rf_we,
  output logic [RW-1:0]    rf_waddr,
  output logic [XLEN-1:0]  rf_wdata,
  output logic             st_req,
  output logic [XLEN-1:0]  st_addr,
  output logic [XLEN-1:0]  st_data,
  output logic             redirect_valid,
  output logic [XLEN-1:0]  redirect_pc
);

  logic head_ready;

  always_comb begin
    head_ready = valid_i[head_idx] && done_i[head_idx];
    pop        = head_ready;
    flush      = 1'b0;
    rf_we      = 1'b0;
    st_req     = 1'b0;
    rf_waddr   = dest_i[head_idx];
    rf_wdata   = value_i[head_idx];
    st_addr    = addr_i[head_idx];
    st_data    = value_i[head_idx];
    if (head_ready && !exc_i[head_idx]) begin
      case (kind_i[head_idx])
        OP_STORE:  st_req = 1'b1;
        OP_BRANCH: flush  = misp_i[head_idx];
        default:   rf_we  = 1'b1;
      endcase
    end
    redirect_valid = flush;
    redirect_pc    = value_i[head_idx];
  end

endmodule

// File: rtl/spec_rob.sv
module spec_rob
  import srob_pkg::*;
#(
  parameter  int unsigned DEPTH = 8,
  parameter  int unsigned XLEN  = 32,
  parameter  int unsigned RW    = 5,
  localparam int unsigned IW    = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc_req,
  input  logic [1:0]      alloc_kind,
  input  logic [RW-1:0]   alloc_dest,
  input  logic [XLEN-1:0] alloc_addr,
  input  logic            alloc_src_rdy,
  input  logic [XLEN-1:0] alloc_src_val,
  input  logic [IW-1:0]   alloc_src_tag,
  output logic            alloc_ok,
  output logic [IW-1:0]   alloc_tag,
  input  logic [IW-1:0]   rd0_tag,
  output logic            rd0_ready,
  output logic [XLEN-1:0] rd0_value,
  input  logic [IW-1:0]   rd1_tag,
  output logic            rd1_ready,
  output logic [XLEN-1:0] rd1_value,
  input  logic            bus_valid,
  input  logic [IW-1:0]   bus_tag,
  input  logic [XLEN-1:0] bus_value,
  input  logic            bus_exc,
  input  logic            bus_mispred,
  output logic            rf_we,
  output logic [RW-1:0]   rf_waddr,
  output logic [XLEN-1:0] rf_wdata,
  output logic            st_req,
  output logic [XLEN-1:0] st_addr,
  output logic [XLEN-1:0] st_data,
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_pc
);

  // Reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic             alloc_fire, full, empty, pop, flush;
  logic [IW-1:0]    tail_idx, head_idx;
  logic [DEPTH-1:0] e_valid, e_done, e_exc, e_misp;
  logic [1:0]       e_kind  [DEPTH];
  logic [RW-1:0]    e_dest  [DEPTH];
  logic [XLEN-1:0]  e_addr  [DEPTH];
  logic [XLEN-1:0]  e_value [DEPTH];

  srob_ptrs #(.DEPTH(DEPTH), .IW(IW)) u_ptrs (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .alloc_req  (alloc_req),
    .flush      (flush),
    .pop        (pop),
    .alloc_fire (alloc_fire),
    .tail_idx   (tail_idx),
    .head_idx   (head_idx),
    .full       (full),
    .empty      (empty)
  );

  assign alloc_ok  = !full;
  assign alloc_tag = tail_idx;

  srob_entries #(.DEPTH(DEPTH), .IW(IW), .XLEN(XLEN), .RW(RW)) u_entries (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .flush         (flush),
    .alloc_fire    (alloc_fire),
    .alloc_idx     (tail_idx),
    .alloc_kind    (alloc_kind),
    .alloc_dest    (alloc_dest),
    .alloc_addr    (alloc_addr),
    .alloc_src_rdy (alloc_src_rdy),
    .alloc_src_val (alloc_src_val),
    .alloc_src_tag (alloc_src_tag),
    .bus_valid     (bus_valid),
    .bus_tag       (bus_tag),
    .bus_value     (bus_value),
    .bus_exc       (bus_exc),
    .bus_mispred   (bus_mispred),
    .pop           (pop),
    .pop_idx       (head_idx),
    .valid_o       (e_valid),
    .done_o        (e_done),
    .exc_o         (e_exc),
    .misp_o        (e_misp),
    .kind_o        (e_kind),
    .dest_o        (e_dest),
    .addr_o        (e_addr),
    .value_o       (e_value)
  );

  srob_lookup #(.DEPTH(DEPTH), .IW(IW), .XLEN(XLEN)) u_look0 (
    .tag     (rd0_tag),
    .valid_i (e_valid),
    .done_i  (e_done),
    .value_i (e_value),
    .ready   (rd0_ready),
    .value   (rd0_value)
  );

  srob_lookup #(.DEPTH(DEPTH), .IW(IW), .XLEN(XLEN)) u_look1 (
    .tag     (rd1_tag),
    .valid_i (e_valid),
    .done_i  (e_done),
    .value_i (e_value),
    .ready   (rd1_ready),
    .value   (rd1_value)
  );

  srob_retire #(.DEPTH(DEPTH), .IW(IW), .XLEN(XLEN), .RW(RW)) u_retire (
    .head_idx       (head_idx),
    .valid_i        (e_valid),
    .done_i         (e_done),
    .exc_i          (e_exc),
    .misp_i         (e_misp),
    .kind_i         (e_kind),
    .dest_i         (e_dest),
    .addr_i         (e_addr),
    .value_i        (e_value),
    .pop            (pop),
    .flush          (flush),
    .rf_we          (rf_we),
    .rf_waddr       (rf_waddr),
    .rf_wdata       (rf_wdata),
    .st_req         (st_req),
    .st_addr        (st_addr),
    .st_data        (st_data),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc)
  );

  // R9: a redirect leaves no entry behind
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_int_n)
    redirect_valid |=> (empty && (e_valid == '0)));

  // R11: nothing retires behind an incomplete head
  a_r11_head_blocks: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(e_valid[head_idx] && e_done[head_idx]) |-> !(rf_we || st_req || redirect_valid));

  // R7: a register commit frees its slot
  a_r7_retired_slot_free: assert property (@(posedge clk) disable iff (!rst_int_n)
    rf_we |=> !e_valid[$past(head_idx)]);

endmodule

// File: tb/test_spec_rob.sv
module test_spec_rob;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        alloc_req, alloc_src_rdy, bus_valid, bus_exc, bus_mispred;
  logic [1:0]  alloc_kind;
  logic [4:0]  alloc_dest;
  logic [31:0] alloc_addr, alloc_src_val, bus_value;
  logic [2:0]  alloc_src_tag, rd0_tag, rd1_tag, bus_tag, alloc_tag;
  logic        alloc_ok, rd0_ready, rd1_ready, rf_we, st_req, redirect_valid;
  logic [31:0] rd0_value, rd1_value, rf_wdata, st_addr, st_data, redirect_pc;
  logic [4:0]  rf_waddr;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit mon_en = 1'b0;

  typedef struct {int kind; logic [31:0] a; logic [31:0] d;} exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  spec_rob i_spec_rob (
    .clk(clk), .rst_n(rst_n),
    .alloc_req(alloc_req), .alloc_kind(alloc_kind), .alloc_dest(alloc_dest),
    .alloc_addr(alloc_addr), .alloc_src_rdy(alloc_src_rdy), .alloc_src_val(alloc_src_val),
    .alloc_src_tag(alloc_src_tag), .alloc_ok(alloc_ok), .alloc_tag(alloc_tag),
    .rd0_tag(rd0_tag), .rd0_ready(rd0_ready), .rd0_value(rd0_value),
    .rd1_tag(rd1_tag), .rd1_ready(rd1_ready), .rd1_value(rd1_value),
    .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_value(bus_value),
    .bus_exc(bus_exc), .bus_mispred(bus_mispred),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .st_req(st_req), .st_addr(st_addr), .st_data(st_data),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
  );

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    alloc_req = 1'b0;
    bus_valid = 1'b0;
    bus_exc   = 1'b0;
    bus_mispred = 1'b0;
  endtask

  task automatic set_alloc(input logic [1:0] k, input int dst, input logic [31:0] adr,
                           input bit srdy, input logic [31:0] sval, input int stag);
    alloc_req     = 1'b1;
    alloc_kind    = k;
    alloc_dest    = dst[4:0];
    alloc_addr    = adr;
    alloc_src_rdy = srdy;
    alloc_src_val = sval;
    alloc_src_tag = stag[2:0];
  endtask

  task automatic set_bus(input int tg, input logic [31:0] v, input bit ex, input bit mp);
    bus_valid   = 1'b1;
    bus_tag     = tg[2:0];
    bus_value   = v;
    bus_exc     = ex;
    bus_mispred = mp;
  endtask

  task automatic alloc(input logic [1:0] k, input int dst, input logic [31:0] adr,
                       input bit srdy, input logic [31:0] sval, input int stag, input int etag);
    set_alloc(k, dst, adr, srdy, sval, stag);
    #1;
    chk(alloc_ok == 1'b1, "R2 slot free", {31'd0, alloc_ok}, 32'd1);
    chk(alloc_tag == etag[2:0], "R3 tag order", {29'd0, alloc_tag}, etag);
    step();
  endtask

  task automatic bus(input int tg, input logic [31:0] v, input bit ex, input bit mp);
    set_bus(tg, v, ex, mp);
    step();
  endtask

  task automatic push(input int k, input logic [31:0] a, input logic [31:0] d);
    exp_t e;
    e.kind = k; e.a = a; e.d = d;
    sb.push_back(e);
  endtask

  task automatic drain();
    for (int k = 0; k < 40 && sb.size() != 0; k++) step();
    step();
    chk(sb.size() == 0, "R1 all expected commits seen", sb.size(), 0);
  endtask

  // Monitor: compares each commit action against the scoreboard
  always @(negedge clk) begin
    if (mon_en && (rf_we || st_req || redirect_valid)) begin
      exp_t e;
      int ak;
      logic [31:0] aa, ad;
      string rq;
      ak = rf_we ? 0 : (st_req ? 1 : 2);
      aa = rf_we ? {27'd0, rf_waddr} : (st_req ? st_addr : redirect_pc);
      ad = rf_we ? rf_wdata : (st_req ? st_data : 32'd0);
      total++;
      if ((32'(rf_we) + 32'(st_req) + 32'(redirect_valid)) > 1) begin
        bad++;
        $display("FAIL R1 more than one action actual=%b expected=one", {rf_we, st_req, redirect_valid});
      end else if (sb.size() == 0) begin
        bad++;
        $display("FAIL R1 unexpected commit kind=%0d actual=%h/%h expected=none", ak, aa, ad);
      end else begin
        e = sb.pop_front();
        rq = (e.kind == 0) ? "R7" : ((e.kind == 1) ? "R8" : "R9");
        if (e.kind != ak || e.a != aa || e.d != ad) begin
          bad++;
          $display("FAIL %s commit actual=%0d/%h/%h expected=%0d/%h/%h", rq, ak, aa, ad, e.kind, e.a, e.d);
        end
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog actual=%0d expected<=20000", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    alloc_req = 0; alloc_kind = 0; alloc_dest = 0; alloc_addr = 0;
    alloc_src_rdy = 0; alloc_src_val = 0; alloc_src_tag = 0;
    rd0_tag = 0; rd1_tag = 0;
    bus_valid = 0; bus_tag = 0; bus_value = 0; bus_exc = 0; bus_mispred = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) step();

    // Reset state
    chk(alloc_ok == 1'b1, "R2 reset alloc_ok", {31'd0, alloc_ok}, 1);
    chk(alloc_tag == 3'd0, "R3 reset tag", {29'd0, alloc_tag}, 0);
    chk(!rf_we && !st_req && !redirect_valid, "R1 reset no action",
        {29'd0, rf_we, st_req, redirect_valid}, 0);
    chk(rd0_ready == 1'b0, "R6 reset lookup", {31'd0, rd0_ready}, 0);
    mon_en = 1'b1;

    // Out-of-order completion, in-order retirement (R1, R3, R4, R6, R7, R11)
    alloc(2'd0, 1, 0, 0, 0, 0, 0);
    alloc(2'd0, 2, 0, 0, 0, 0, 1);
    alloc(2'd0, 3, 0, 0, 0, 0, 2);
    bus(2, 32'h33, 0, 0);
    bus(1, 32'h22, 0, 0);
    step();
    chk(!rf_we, "R11 head incomplete blocks", {31'd0, rf_we}, 0);
    rd0_tag = 3'd2; rd1_tag = 3'd0;
    #1;
    chk(rd0_ready && rd0_value == 32'h33, "R6 forward complete", rd0_value, 32'h33);
    chk(!rd1_ready, "R6 incomplete not ready", {31'd0, rd1_ready}, 0);
    rd1_tag = 3'd1;
    #1;
    chk(rd1_ready && rd1_value == 32'h22, "R4 value captured", rd1_value, 32'h22);
    push(0, 1, 32'h11); push(0, 2, 32'h22); push(0, 3, 32'h33);
    bus(0, 32'h11, 0, 0);
    drain();

    // Stores: data at issue, late snoop, same-cycle snoop (R5, R8)
    push(0, 4, 32'h55); push(1, 32'h100, 32'hAA); push(1, 32'h104, 32'h55);
    alloc(2'd0, 4, 0, 0, 0, 0, 3);
    alloc(2'd1, 0, 32'h100, 1, 32'hAA, 0, 4);
    alloc(2'd1, 0, 32'h104, 0, 0, 3, 5);
    bus(3, 32'h55, 0, 0);
    drain();
    push(0, 5, 32'h66); push(1, 32'h108, 32'h66);
    alloc(2'd0, 5, 0, 0, 0, 0, 6);
    set_alloc(2'd1, 0, 32'h108, 0, 0, 6);
    set_bus(6, 32'h66, 0, 0);
    #1;
    chk(alloc_tag == 3'd7, "R5 same-cycle store tag", {29'd0, alloc_tag}, 7);
    step();
    drain();

    // Exception entry retires silently; tag wraps to 0 (R10, R3)
    alloc(2'd0, 7, 0, 0, 0, 0, 0);
    bus(0, 32'h70, 1, 0);
    push(0, 8, 32'h77);
    alloc(2'd0, 8, 0, 0, 0, 0, 1);
    bus(1, 32'h77, 0, 0);
    drain();

    // Full buffer (R2)
    for (int k = 0; k < 8; k++) alloc(2'd0, 16 + k, 0, 0, 0, 0, (2 + k) % 8);
    set_alloc(2'd0, 31, 0, 0, 0, 0);
    #1;
    chk(alloc_ok == 1'b0, "R2 full blocks", {31'd0, alloc_ok}, 0);
    step();
    chk(alloc_tag == 3'd2, "R2 refused alloc keeps tag", {29'd0, alloc_tag}, 2);
    for (int k = 0; k < 8; k++) push(0, 16 + k, 32'h1000 + k);
    for (int k = 0; k < 8; k++) bus((2 + k) % 8, 32'h1000 + k, 0, 0);
    drain();
    chk(alloc_ok && alloc_tag == 3'd2, "R2 after drain", {29'd0, alloc_tag}, 2);

    // Correct branch retires silently (R9)
    push(0, 9, 32'h99);
    alloc(2'd2, 0, 0, 0, 0, 0, 2);
    alloc(2'd0, 9, 0, 0, 0, 0, 3);
    bus(3, 32'h99, 0, 0);
    bus(2, 32'h400, 0, 0);
    drain();

    // Mispredicted branch flushes; same-cycle alloc dropped (R9)
    alloc(2'd2, 0, 0, 0, 0, 0, 4);
    alloc(2'd0, 10, 0, 0, 0, 0, 5);
    push(2, 32'h1234, 0);
    bus(5, 32'hAB, 0, 0);
    bus(4, 32'h1234, 0, 1);
    set_alloc(2'd0, 11, 0, 0, 0, 0);
    step();
    rd0_tag = 3'd5;
    #1;
    chk(alloc_tag == 3'd0, "R9 tags restart, alloc dropped", {29'd0, alloc_tag}, 0);
    chk(!rd0_ready, "R9 younger entry cleared", {31'd0, rd0_ready}, 0);
    drain();
    push(0, 12, 32'hC0DE);
    alloc(2'd0, 12, 0, 0, 0, 0, 0);
    bus(0, 32'hC0DE, 0, 0);
    drain();

    summary();
    $finish;
  end

endmodule